// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block governs the low-power sleep state of a synchronous pipelined memory. A sleep request arrives on a pin with no timing relationship to the clock. The block resynchronises it and then steps through a fixed entry window, a sleep state, a fixed exit window and back to normal operation. From that sequence it drives three controls. An input-accept enable tells the surrounding logic whether its synchronous command, address and data registers may load. An output override forces the data drivers to high impedance. A power-down flag tells the storage array it may drop to its retention state.

The windows on either side of sleep are guard periods. During the entry window reads and deselects still pass, but no write may reach the array. During the exit window nothing is accepted while the array wakes. The block also gates write strobes through to the array, so a write issued in a guard window or during sleep has no effect. After reset, and again after every sleep, the data drivers stay in high impedance until a read has been accepted.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: After reset, in_accept is 1, array_pdown is 0, dq_hiz is 1, and wr_commit follows wr_strobe.
- R2: A read (rd_strobe high while in_accept is 1) clears dq_hiz from the following cycle onward.
- R3: SYNC_STAGES+1 clock edges after sleep_req is first sampled high, the entry window begins. It lasts ENTRY_CYC cycles, during which in_accept stays 1 and wr_commit is 0 whatever wr_strobe does.
- R4: When the entry window ends, in_accept becomes 0 and array_pdown and dq_hiz become 1 until the exit window.
- R5: While asleep, rd_strobe and wr_strobe have no effect: wr_commit stays 0, and a read during sleep does not release dq_hiz after waking.
- R6: SYNC_STAGES+1 clock edges after sleep_req is first sampled low during sleep, array_pdown returns to 0. in_accept stays 0 for EXIT_CYC cycles and then returns to 1.
- R7: After every sleep, dq_hiz stays 1 on return to the awake state until a new read is accepted.
- R8: A sleep_req pulse of one clock cycle still produces the complete sequence: an entry window of ENTRY_CYC cycles, at least one sleep cycle, and an exit window of EXIT_CYC cycles.
- R9: In the awake state with no pending request, wr_commit equals wr_strobe in the same cycle.
- R10: A request that rises again during the exit window does not shorten it. The block returns to the awake state, and then starts a new entry window once the request has been synchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| rd_strobe | input | 1 | A read is being issued this cycle |
| wr_strobe | input | 1 | A write is being issued this cycle |
| in_accept | output | 1 | Synchronous input registers may load |
| dq_hiz | output | 1 | Force data outputs to high impedance |
| array_pdown | output | 1 | Storage array power-down indication |
| wr_commit | output | 1 | Write permitted to reach the array |

## Verification
The bench builds the block with SYNC_STAGES=2, ENTRY_CYC=3 and EXIT_CYC=2. Because the entry and exit windows differ in length, an off-by-one or a swapped counter load in either window shows up at a distinct sample point. Because EXIT_CYC equals SYNC_STAGES, a request raised at the start of the exit window is synchronised exactly when the block becomes awake. That makes the exit-then-reentry ordering observable in a single awake cycle.

// File: rtl/mem_sleep_pkg.sv
package mem_sleep_pkg;

    typedef enum logic [1:0] {
        PS_AWAKE = 2'd0,
        PS_ENTER = 2'd1,
        PS_SLEEP = 2'd2,
        PS_EXIT  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic accept;    // synchronous inputs may load
        logic wr_allow;  // writes may reach the array
        logic force_hiz; // state forces outputs off
        logic pdown;     // array in power-down
    } ctl_t;

    function automatic ctl_t decode_state(input pwr_state_e st);
        ctl_t c;
        c = '0;
        case (st)
            PS_AWAKE: begin c.accept = 1'b1; c.wr_allow = 1'b1; end
            PS_ENTER: begin c.accept = 1'b1; end
            PS_SLEEP: begin c.force_hiz = 1'b1; c.pdown = 1'b1; end
            PS_EXIT:  begin c.force_hiz = 1'b1; end
            default:  begin c.force_hiz = 1'b1; end
        endcase
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mem_sleep_sync.sv
module mem_sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= async_in;
            end
            assign sync_out = q;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
            assign sync_out = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mem_sleep_seq.sv
module mem_sleep_seq
    import mem_sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_sync,
    output pwr_state_e state
);
    localparam int MAXW = max_of(ENTRY_CYC, EXIT_CYC);
    localparam int CW   = (MAXW < 2) ? 1 : $clog2(MAXW + 1);
    localparam logic [CW-1:0] ENTRY_LOAD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LOAD  = CW'(EXIT_CYC - 1);

    pwr_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            PS_AWAKE: begin
                if (req_sync) begin
                    st_d  = PS_ENTER;
                    cnt_d = ENTRY_LOAD;
                end
            end
            PS_ENTER: begin
                // Entry always completes, even if the request drops.
                if (cnt_zero) st_d = PS_SLEEP;
                else          cnt_d = cnt_q - 1'b1;
            end
            PS_SLEEP: begin
                if (!req_sync) begin
                    st_d  = PS_EXIT;
                    cnt_d = EXIT_LOAD;
                end
            end
            PS_EXIT: begin
                if (cnt_zero) st_d = PS_AWAKE;
                else          cnt_d = cnt_q - 1'b1;
            end
            default: st_d = PS_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_AWAKE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/mem_sleep_outs.sv
module mem_sleep_outs
    import mem_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_state_e state,
    input  logic       rd_strobe,
    input  logic       wr_strobe,
    output logic       in_accept,
    output logic       dq_hiz,
    output logic       array_pdown,
    output logic       wr_commit
);
    ctl_t ctl;
    logic rd_seen_q;

    assign ctl = decode_state(state);

    // Drivers stay off until a read has been taken; cleared by sleep.
    always_ff @(posedge clk) begin
        if (rst)                        rd_seen_q <= 1'b0;
        else if (ctl.pdown)             rd_seen_q <= 1'b0;
        else if (rd_strobe && ctl.accept) rd_seen_q <= 1'b1;
    end

    assign in_accept   = ctl.accept;
    assign array_pdown = ctl.pdown;
    assign dq_hiz      = ctl.force_hiz | ~rd_seen_q;
    assign wr_commit   = wr_strobe & ctl.wr_allow;
endmodule

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl
    import mem_sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic rd_strobe,
    input  logic wr_strobe,
    output logic in_accept,
    output logic dq_hiz,
    output logic array_pdown,
    output logic wr_commit
);
    logic       req_sync;
    pwr_state_e state;

    mem_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sleep_req),
        .sync_out (req_sync)
    );

    mem_sleep_seq #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_sync (req_sync),
        .state    (state)
    );

    mem_sleep_outs u_outs (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .in_accept   (in_accept),
        .dq_hiz      (dq_hiz),
        .array_pdown (array_pdown),
        .wr_commit   (wr_commit)
    );
endmodule

// File: rtl/mem_sleep_ctrl_chk.sv
module mem_sleep_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic in_accept,
    input logic dq_hiz,
    input logic array_pdown,
    input logic wr_commit
);
    // R4: power-down state closes inputs and forces outputs off
    a_r4_sleep_closes_inputs: assert property (@(posedge clk) disable iff (rst)
        array_pdown |-> (!in_accept && dq_hiz));

    // R3: power-down is only ever entered from an entry window
    a_r3_entry_precedes_sleep: assert property (@(posedge clk) disable iff (rst)
        $rose(array_pdown) |-> ($past(in_accept) && !$past(wr_commit)));

    // R6: array wakes before inputs are accepted again
    a_r6_wake_before_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(array_pdown) |-> !in_accept);

    // R9: a committed write needs a request and open inputs
    a_r9_commit_needs_request: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (wr_strobe && in_accept));

    // R2: drivers are released only after an accepted read
    a_r2_release_by_read: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_hiz) |-> ($past(rd_strobe) && $past(in_accept)));
endmodule

bind mem_sleep_ctrl mem_sleep_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .in_accept   (in_accept),
    .dq_hiz      (dq_hiz),
    .array_pdown (array_pdown),
    .wr_commit   (wr_commit)
);

// File: tb/mem_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module mem_sleep_ctrl_bench;
    localparam int SYNC  = 2;
    localparam int ENTRY = 3;
    localparam int EXITC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic rd_strobe = 1'b0;
    logic wr_strobe = 1'b0;
    logic in_accept, dq_hiz, array_pdown, wr_commit;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mem_sleep_ctrl #(.SYNC_STAGES(SYNC), .ENTRY_CYC(ENTRY), .EXIT_CYC(EXITC)) u_mem_sleep_ctrl (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .in_accept(in_accept), .dq_hiz(dq_hiz),
        .array_pdown(array_pdown), .wr_commit(wr_commit)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        // R1
        check("R1 accept", in_accept, 1'b1);
        check("R1 pdown", array_pdown, 1'b0);
        check("R1 hiz", dq_hiz, 1'b1);
        wr_strobe = 1'b1; #1;
        check("R9 commit follows write", wr_commit, 1'b1);
        wr_strobe = 1'b0; #1;
        check("R9 commit low", wr_commit, 1'b0);
    endtask

    task automatic t_first_read;
        rd_strobe = 1'b1; #1;
        check("R2 hiz before edge", dq_hiz, 1'b1);
        tick();
        rd_strobe = 1'b0;
        check("R2 hiz released", dq_hiz, 1'b0);
    endtask

    task automatic do_enter;
        sleep_req = 1'b1;
        wr_strobe = 1'b1;
        tick(SYNC);
        check("R9 still awake", wr_commit, 1'b1);
        tick();
        check("R3 window accept", in_accept, 1'b1);
        check("R3 window write blocked", wr_commit, 1'b0);
        check("R3 window no pdown", array_pdown, 1'b0);
        tick(ENTRY - 1);
        check("R3 window end accept", in_accept, 1'b1);
        check("R3 window end blocked", wr_commit, 1'b0);
        tick();
        check("R4 accept off", in_accept, 1'b0);
        check("R4 pdown on", array_pdown, 1'b1);
        check("R4 hiz on", dq_hiz, 1'b1);
        wr_strobe = 1'b0;
    endtask

    task automatic do_exit;
        sleep_req = 1'b0;
        tick(SYNC);
        check("R6 still asleep", array_pdown, 1'b1);
        tick();
        check("R6 pdown off", array_pdown, 1'b0);
        check("R6 accept held", in_accept, 1'b0);
        tick(EXITC - 1);
        check("R6 accept held end", in_accept, 1'b0);
        tick();
        check("R6 accept back", in_accept, 1'b1);
    endtask

    task automatic t_sleep_cycle;
        do_enter();
        // R5: strobes while asleep
        rd_strobe = 1'b1; wr_strobe = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1 check("R5 no commit asleep", wr_commit, 1'b0);
            tick();
        end
        rd_strobe = 1'b0; wr_strobe = 1'b0;
        do_exit();
        check("R5 R7 hiz after wake", dq_hiz, 1'b1);
        tick();
        check("R7 hiz held idle", dq_hiz, 1'b1);
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        check("R7 hiz released by read", dq_hiz, 1'b0);
    endtask

    task automatic t_short_pulse;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        wr_strobe = 1'b1;
        tick(SYNC);
        check("R8 entry started", wr_commit, 1'b0);
        check("R8 entry accept", in_accept, 1'b1);
        tick(ENTRY);
        check("R8 reached sleep", array_pdown, 1'b1);
        tick();
        check("R8 exit started", array_pdown, 1'b0);
        check("R8 exit accept", in_accept, 1'b0);
        tick(EXITC);
        check("R8 awake", in_accept, 1'b1);
        check("R8 write again", wr_commit, 1'b1);
        wr_strobe = 1'b0;
    endtask

    task automatic t_reentry;
        do_enter();
        sleep_req = 1'b0;
        tick(SYNC + 1);
        check("R10 exit begun", array_pdown, 1'b0);
        sleep_req = 1'b1;
        wr_strobe = 1'b1;
        tick(EXITC);
        check("R10 exit not shortened", in_accept, 1'b1);
        check("R10 awake commit", wr_commit, 1'b1);
        tick();
        check("R10 reentry blocked", wr_commit, 1'b0);
        check("R10 reentry accept", in_accept, 1'b1);
        tick(ENTRY);
        check("R10 asleep again", array_pdown, 1'b1);
        wr_strobe = 1'b0;
        sleep_req = 1'b0;
        tick(SYNC + 1 + EXITC);
        check("R10 final awake", in_accept, 1'b1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_first_read();
        t_sleep_cycle();
        t_short_pulse();
        t_reentry();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule